// File: doc/BRIEF.md
# Endpoint Transfer-Mode Register Bank

This block keeps the transfer configuration of the three non-control endpoints of a USB device controller. Each endpoint has one byte-wide mode register. The register selects the data direction, the transfer type and a payload-size code. The block turns the payload code into a maximum packet length in bytes, so that the packet engine can use it directly. Firmware reaches the registers over a simple byte-addressed bus with separate read and write strobes. Reads are combinational, and writes take effect on the clock edge.

Each accepted write pulses an initialization line for the endpoint it addressed, so that the packet engine resets that endpoint. A small gating state machine decides whether a write is accepted. It has three states:
- `GS_OPEN`: writes are accepted.
- `GS_SETTLE`: the recovery countdown started by the last accepted write is still running.
- `GS_GUARD`: configuration requests are handled by software, a setup interrupt has arrived, and the end-of-packet register has not yet been touched.

The transitions are as follows:
- `GS_OPEN` goes to `GS_SETTLE` on an accepted write.
- `GS_OPEN` or `GS_SETTLE` goes to `GS_GUARD` on a setup interrupt while `sw_cfg` is high.
- `GS_SETTLE` goes to `GS_OPEN` when the countdown expires.
- `GS_GUARD` goes to `GS_SETTLE` on an end-of-packet access if more than one recovery cycle is left, and to `GS_OPEN` otherwise.

Writes that arrive outside `GS_OPEN` are dropped without any effect.

Top module: `ep_cfg_bank`

## Requirements
- R1: Endpoint k (k = 1..3) is mapped at byte address BASE_ADDR + k - 1, which is 0x0789, 0x078A and 0x078B by default. An accepted write stores bus_wdata into the addressed register only. A write to any other address changes nothing and produces no pulse.
- R2: Register bit 0 drives the endpoint's `ep_dir` bit, where 0 means OUT (host to device) and 1 means IN. Bits 2:1 drive the endpoint's 2-bit field of `ep_xfer`: 00 is control, 01 is isochronous, 10 is bulk or interrupt, and 11 is interrupt without data toggle.
- R3: Bits 5:3 hold a payload code c. The endpoint's 11-bit slice of `ep_maxpkt` (bits 11(k-1)+10 down to 11(k-1)) shows 8·2^c bytes for c = 0..6, and shows 1023 for c = 7.
- R4: When `bus_rd` is high and the address is mapped, `bus_rdata` returns the register in the same cycle, with bits 7:6 always 0. Written values of bits 7:6 are discarded. When `bus_rd` is low or the address is unmapped, `bus_rdata` is 0.
- R5: Reset clears every register to 0. After reset, each `ep_maxpkt` slice is 8, and `ep_init` and `busy` are 0.
- R6: An accepted write raises exactly one `ep_init` bit, the one for the addressed endpoint. That bit is high for exactly the one cycle after the write edge.
- R7: After an accepted write, `busy` is high for RECOVER_CYC cycles. Writes sampled in that period are dropped.
- R8: While `sw_cfg` is high, a `setup_irq` pulse drops any write in the same cycle. It also drops every later write up to and including the cycle in which `eop_access` is high. While `sw_cfg` is low, `setup_irq` has no effect.
- R9: If the guard window closes while recovery cycles remain, writes stay blocked until `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_cfg | input | 1 | Configuration requests are handled by software |
| setup_irq | input | 1 | Setup interrupt pulse |
| eop_access | input | 1 | Pulse when software accesses the end-of-packet register |
| bus_addr | input | 16 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| ep_dir | output | 3 | Direction per endpoint |
| ep_xfer | output | 6 | Transfer type per endpoint, 2 bits each |
| ep_maxpkt | output | 33 | Maximum packet bytes per endpoint, 11 bits each |
| ep_init | output | 3 | Endpoint initialization pulse |
| busy | output | 1 | Recovery period after an accepted write |

## Verification
Read data is due in the same cycle as the strobe, so the bench samples `bus_rdata` a nanosecond after the falling edge, against the register values from before that cycle's write. The following results are all due one rising edge after the write cycle, and the bench samples them one nanosecond after that edge:
- the register-driven outputs (`ep_dir`, `ep_xfer`, `ep_maxpkt`);
- the `ep_init` pulse;
- the rise of `busy`.

`busy` then falls RECOVER_CYC edges later. The bench's reference model decrements its own count once per step, so every sample sees exactly the number of remaining blocked cycles that R7 and R9 require.

// File: rtl/ep_cfg_pkg.sv
package ep_cfg_pkg;

    localparam int PKT_W = 11;
    localparam logic [7:0] MODE_MASK = 8'h3F;

    typedef enum logic [1:0] {
        GS_OPEN   = 2'd0,
        GS_SETTLE = 2'd1,
        GS_GUARD  = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic [1:0] rsv;
        logic [2:0] pay;
        logic [1:0] xfer;
        logic       dir;
    } ep_mode_t;

    function automatic logic [PKT_W-1:0] pay_to_bytes(input logic [2:0] code);
        if (code == 3'd7) begin
            return PKT_W'(1023);
        end
        return PKT_W'(8) << code;
    endfunction

endpackage

// File: rtl/ep_cfg_gate.sv
module ep_cfg_gate
    import ep_cfg_pkg::*;
#(
    parameter int RECOVER_CYC = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_cfg,
    input  logic setup_irq,
    input  logic eop_access,
    input  logic wr_hit,
    output logic wr_accept,
    output logic busy
);

    localparam int CW = $clog2(RECOVER_CYC + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(RECOVER_CYC);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    gate_state_e    st_q, st_d;
    logic [CW-1:0]  cnt_q;
    logic           setup_hit;

    assign setup_hit = sw_cfg && setup_irq;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= GS_OPEN;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GS_OPEN: begin
                if (setup_hit) begin
                    st_d = GS_GUARD;
                end else if (wr_hit) begin
                    st_d = GS_SETTLE;
                end
            end
            GS_SETTLE: begin
                if (setup_hit) begin
                    st_d = GS_GUARD;
                end else if (cnt_q == CNT_ONE) begin
                    st_d = GS_OPEN;
                end
            end
            GS_GUARD: begin
                if (eop_access) begin
                    st_d = (cnt_q > CNT_ONE) ? GS_SETTLE : GS_OPEN;
                end
            end
            default: st_d = GS_OPEN;
        endcase
    end

    // recovery countdown, runs in every state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_accept) begin
            cnt_q <= CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // outputs
    always_comb begin
        wr_accept = wr_hit && (st_q == GS_OPEN) && !setup_hit;
        busy      = (cnt_q != '0);
    end

endmodule

// File: rtl/ep_cfg_slot.sv
module ep_cfg_slot
    import ep_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  logic [7:0] wdata,
    output ep_mode_t mode,
    output logic     init_pulse
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode       <= '0;
            init_pulse <= 1'b0;
        end else begin
            init_pulse <= load;
            if (load) begin
                mode <= ep_mode_t'(wdata & MODE_MASK);
            end
        end
    end

endmodule

// File: rtl/ep_cfg_bank.sv
module ep_cfg_bank
    import ep_cfg_pkg::*;
#(
    parameter int NUM_EP      = 3,
    parameter int ADDR_W      = 16,
    parameter int BASE_ADDR   = 16'h0789,
    parameter int RECOVER_CYC = 84
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sw_cfg,
    input  logic                    setup_irq,
    input  logic                    eop_access,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    output logic [NUM_EP-1:0]       ep_dir,
    output logic [2*NUM_EP-1:0]     ep_xfer,
    output logic [PKT_W*NUM_EP-1:0] ep_maxpkt,
    output logic [NUM_EP-1:0]       ep_init,
    output logic                    busy
);

    logic [NUM_EP-1:0] sel;
    ep_mode_t          mode_q [NUM_EP];
    logic              wr_hit;
    logic              wr_accept;

    assign wr_hit = bus_wr && (|sel);

    ep_cfg_gate #(.RECOVER_CYC(RECOVER_CYC)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_cfg     (sw_cfg),
        .setup_irq  (setup_irq),
        .eop_access (eop_access),
        .wr_hit     (wr_hit),
        .wr_accept  (wr_accept),
        .busy       (busy)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        assign sel[i] = (bus_addr == ADDR_W'(BASE_ADDR + i));

        ep_cfg_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (wr_accept && sel[i]),
            .wdata      (bus_wdata),
            .mode       (mode_q[i]),
            .init_pulse (ep_init[i])
        );

        assign ep_dir[i]                    = mode_q[i].dir;
        assign ep_xfer[2*i +: 2]            = mode_q[i].xfer;
        assign ep_maxpkt[PKT_W*i +: PKT_W]  = pay_to_bytes(mode_q[i].pay);
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (bus_rd && sel[i]) begin
                bus_rdata = mode_q[i];
            end
        end
    end

endmodule

// File: rtl/ep_cfg_bank_chk.sv
module ep_cfg_bank_chk #(
    parameter int NUM_EP = 3,
    parameter int PKT_W  = 11
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [7:0]              bus_rdata,
    input logic [NUM_EP-1:0]       ep_init,
    input logic [PKT_W*NUM_EP-1:0] ep_maxpkt,
    input logic                    busy
);

    p_init_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ep_init));

    p_init_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ep_init) |=> !(|ep_init));

    p_init_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ep_init) |-> $past(bus_wr));

    p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (|ep_init));

    p_busy_drops_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr) |=> !(|ep_init));

    p_rsv_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:6] == 2'b00);

    for (genvar i = 0; i < NUM_EP; i++) begin : g_sz
        p_maxpkt_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (($countones(ep_maxpkt[PKT_W*i +: PKT_W]) == 1)
              && (ep_maxpkt[PKT_W*i +: PKT_W] >= PKT_W'(8))
              && (ep_maxpkt[PKT_W*i +: PKT_W] <= PKT_W'(512)))
            || (ep_maxpkt[PKT_W*i +: PKT_W] == PKT_W'(1023)));
    end

endmodule

bind ep_cfg_bank ep_cfg_bank_chk #(.NUM_EP(NUM_EP), .PKT_W(ep_cfg_pkg::PKT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .ep_init   (ep_init),
    .ep_maxpkt (ep_maxpkt),
    .busy      (busy)
);

// File: tb/ep_cfg_bank_test.sv
`timescale 1ns/1ps
module ep_cfg_bank_test;

    localparam int NEP  = 3;
    localparam int RCY  = 10;
    localparam int BASE = 16'h0789;

    logic        clk = 1'b0;
    logic        rst_n, sw_cfg, setup_irq, eop_access, bus_wr, bus_rd;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [NEP-1:0]    ep_dir, ep_init;
    logic [2*NEP-1:0]  ep_xfer;
    logic [11*NEP-1:0] ep_maxpkt;
    logic        busy;

    always #2.5 clk = ~clk;

    ep_cfg_bank #(.NUM_EP(NEP), .RECOVER_CYC(RCY)) uut (
        .clk(clk), .rst_n(rst_n), .sw_cfg(sw_cfg), .setup_irq(setup_irq),
        .eop_access(eop_access), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ep_dir(ep_dir), .ep_xfer(ep_xfer), .ep_maxpkt(ep_maxpkt),
        .ep_init(ep_init), .busy(busy)
    );

    int         n_run = 0, n_fail = 0;
    logic [5:0] m_reg [NEP];
    int         m_cnt;
    bit         m_guard;

    function automatic logic [10:0] exp_bytes(input logic [2:0] c);
        if (c == 3'd7) return 11'd1023;
        return 11'd8 << c;
    endfunction

    task automatic chk(input string tag, input longint got, input longint exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic chk_outputs();
        for (int i = 0; i < NEP; i++) begin
            chk("R2 direction", ep_dir[i], m_reg[i][0]);
            chk("R2 transfer type", ep_xfer[2*i +: 2], m_reg[i][2:1]);
            chk("R3 max packet", ep_maxpkt[11*i +: 11], exp_bytes(m_reg[i][5:3]));
        end
    endtask

    task automatic step(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        input bit su, input bit eop, input bit rd);
        int idx;
        bit hit, acc;
        logic [NEP-1:0] exp_init;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        setup_irq = su; eop_access = eop; bus_rd = rd;
        idx = int'(a) - BASE;
        hit = (idx >= 0) && (idx < NEP);
        #1;
        if (rd) chk("R4 readback", bus_rdata, hit ? {2'b00, m_reg[idx]} : 8'h00);
        acc = wr && hit && !m_guard && (m_cnt == 0) && !(su && sw_cfg);
        exp_init = '0;
        if (acc) begin
            m_reg[idx] = d[5:0];
            m_cnt = RCY;
            exp_init[idx] = 1'b1;
        end else if (m_cnt > 0) begin
            m_cnt--;
        end
        if (!m_guard && su && sw_cfg) m_guard = 1'b1;
        else if (m_guard && eop) m_guard = 1'b0;
        @(posedge clk);
        #1;
        chk("R6/R7/R8 init pulse", ep_init, exp_init);
        chk("R7/R9 busy", busy, m_cnt != 0);
        chk_outputs();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 16'h0000, 8'h00, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst_n = 0; sw_cfg = 1; setup_irq = 0; eop_access = 0;
        bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
        for (int i = 0; i < NEP; i++) m_reg[i] = '0;
        m_cnt = 0; m_guard = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R5 reset init", ep_init, 0);
        chk("R5 reset busy", busy, 0);
        chk_outputs();
        rst_n = 1;

        // R1/R4: write all ones to endpoint 1, reserved bits must vanish
        step(1, 16'(BASE), 8'hFF, 0, 0, 0);
        // R7: writes during recovery dropped
        step(1, 16'(BASE + 1), 8'h15, 0, 0, 0);
        idle(RCY - 2);
        step(1, 16'(BASE + 2), 8'h2A, 0, 0, 1);
        step(0, 16'(BASE), 8'h00, 0, 0, 1);
        chk("R4 reserved bits", bus_rdata, 8'h3F);
        idle(RCY);
        // R1: unmapped addresses
        step(1, 16'(BASE - 1), 8'h3F, 0, 0, 1);
        step(1, 16'(BASE + 3), 8'h3F, 0, 0, 1);
        // R2/R3: every payload code and type on endpoint 2
        for (int c = 0; c < 8; c++) begin
            step(1, 16'(BASE + 1), {2'b11, 3'(c), 2'(c), 1'(c)}, 0, 0, 0);
            idle(RCY);
            step(0, 16'(BASE + 1), 8'h00, 0, 0, 1);
        end
        // R8: setup in same cycle as write, window until eop
        sw_cfg = 1;
        step(1, 16'(BASE + 2), 8'h09, 1, 0, 0);
        step(1, 16'(BASE + 2), 8'h0A, 0, 0, 0);
        idle(3);
        step(1, 16'(BASE + 2), 8'h0B, 0, 1, 0);
        step(1, 16'(BASE + 2), 8'h0C, 0, 0, 1);
        idle(RCY);
        // R8: sw_cfg low, setup ignored
        sw_cfg = 0;
        step(1, 16'(BASE), 8'h11, 1, 0, 0);
        idle(RCY);
        step(1, 16'(BASE), 8'h12, 0, 0, 1);
        // R9: window opens and closes during recovery
        sw_cfg = 1;
        step(1, 16'(BASE + 1), 8'h21, 1, 0, 0);
        step(0, 16'h0, 8'h00, 0, 1, 0);
        step(1, 16'(BASE + 1), 8'h22, 0, 0, 0);
        idle(RCY);
        step(1, 16'(BASE + 1), 8'h23, 0, 0, 1);
        idle(RCY);

        // random mix
        for (int k = 0; k < 4000; k++) begin
            if (($urandom % 64) == 0) sw_cfg = ~sw_cfg;
            step(($urandom % 2) == 1,
                 16'(BASE - 1 + int'($urandom % 5)),
                 8'($urandom),
                 ($urandom % 40) == 0,
                 ($urandom % 8) == 0,
                 ($urandom % 2) == 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule